// File: doc/BRIEF.md
# Decode-Stage Branch Resolution Unit

This block settles conditional branches and jumps while the instruction is still in decode, so a taken branch costs one fetch slot instead of three. A zero or non-zero test runs on the register value read in that cycle. A dedicated adder forms the branch destination from the sequential PC and the scaled immediate. Jumps build their destination from the upper sequential-PC bits and a 26-bit target field.

The unit drives a PC redirect with its destination. It also owns the fetch/decode latch. In predict-not-taken mode, a taken branch or jump turns the already fetched sequential instruction into a no-op. In delayed mode that instruction always proceeds. When the compared register comes from the ALU instruction just ahead, the branch waits exactly one cycle before it resolves.

Top module: `branch_resolve_unit`

## Requirements
- R1: After reset the decode latch output is the no-op word 32'h0000_0000, and with `valid_i` low no redirect, flush or stall is raised.
- R2: Kind encoding is 2'b00 none, 2'b01 branch-if-zero, 2'b10 branch-if-nonzero, 2'b11 jump. A branch-if-zero redirects exactly when `rs_val_i` is zero, and a branch-if-nonzero redirects exactly when it is not zero.
- R3: For both conditional kinds, `target_o` equals `seq_pc_i` plus the sign-extended 16-bit `imm_i` shifted left by 2.
- R4: A jump always redirects, and `target_o` is `{seq_pc_i[31:28], jtgt_i, 2'b00}`.
- R5: With `delay_mode_i` low, `flush_o` is high exactly when `redirect_o` is high. A branch that is not taken raises neither.
- R6: With `delay_mode_i` high, `flush_o` is never raised, including on taken branches and jumps.
- R7: In the cycle after `flush_o`, the decode latch output is the no-op word 32'h0.
- R8: With no flush and no stall, the decode latch output after a clock edge equals the `fetch_instr_i` value present before that edge.
- R9: A conditional branch with `dep_alu_i` high stalls for exactly one cycle. In that cycle `stall_o` is high, no redirect is raised and the decode latch holds its value. In the following cycle the branch resolves, even if `dep_alu_i` is still high.
- R10: Kind none, or `valid_i` low, raises no redirect, flush or stall. A jump never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Decode slot holds a real instruction |
| br_kind_i | input | 2 | Branch kind (see R2) |
| rs_val_i | input | 32 | Register value tested for zero |
| imm_i | input | 16 | Branch displacement in words |
| jtgt_i | input | 26 | Jump target field |
| seq_pc_i | input | 32 | Sequential PC (branch PC + 4) |
| delay_mode_i | input | 1 | 1: delayed-branch mode, 0: predict-not-taken |
| dep_alu_i | input | 1 | Tested register is written by the ALU instruction just ahead |
| fetch_instr_i | input | 32 | Instruction word from fetch |
| redirect_o | output | 1 | Select `target_o` as next PC |
| target_o | output | 32 | Branch or jump destination |
| flush_o | output | 1 | Squash the fetched instruction |
| stall_o | output | 1 | Hold fetch and decode one cycle |
| dec_instr_o | output | 32 | Fetch/decode latch contents |

## Verification
The assertions assume the surrounding pipeline asserts `dep_alu_i` only with a real instruction in decode. They also assume `delay_mode_i` and `valid_i` settle before the clock edge, because redirect and flush are combinational in the same cycle. The stimulus changes all inputs only on the falling edge. It draws zero register values and dependency flags often, so both stall and no-stall paths run under both modes. It also includes back-to-back dependent branches, which exercise the single-cycle wait limit.

// File: rtl/bru_pkg.sv
package bru_pkg;
  typedef enum logic [1:0] {
    BK_NONE = 2'b00,
    BK_BEQZ = 2'b01,
    BK_BNEZ = 2'b10,
    BK_JUMP = 2'b11
  } br_kind_e;
endpackage

// File: rtl/bru_cond.sv
module bru_cond
  import bru_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  br_kind_e          kind_i,
  input  logic [XLEN-1:0]   operand_i,
  output logic              taken_o
);
  logic is_zero;
  assign is_zero = (operand_i == '0);

  always_comb begin
    unique case (kind_i)
      BK_BEQZ: taken_o = is_zero;
      BK_BNEZ: taken_o = !is_zero;
      BK_JUMP: taken_o = 1'b1;
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bru_target.sv
module bru_target #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int JT_W  = 26
) (
  input  logic [XLEN-1:0]  seq_pc_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [JT_W-1:0]  jtgt_i,
  input  logic             is_jump_i,
  output logic [XLEN-1:0]  target_o
);
  localparam int HI_W  = XLEN - JT_W - 2;
  localparam int EXT_W = XLEN - IMM_W - 2;

  logic [XLEN-1:0] disp;
  logic [XLEN-1:0] br_tgt;
  logic [XLEN-1:0] j_tgt;

  // word displacement -> byte offset
  assign disp   = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, 2'b00};
  assign br_tgt = seq_pc_i + disp;
  assign j_tgt  = {seq_pc_i[XLEN-1 -: HI_W], jtgt_i, 2'b00};

  assign target_o = is_jump_i ? j_tgt : br_tgt;
endmodule

// File: rtl/bru_ifid.sv
module bru_ifid #(
  parameter int          XLEN = 32,
  parameter logic [31:0] NOP  = 32'h0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic            stall_i,
  input  logic [XLEN-1:0] instr_i,
  output logic [XLEN-1:0] instr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      instr_o <= NOP[XLEN-1:0];
    else if (flush_i) instr_o <= NOP[XLEN-1:0];
    else if (!stall_i) instr_o <= instr_i;
  end

  assert_flush_nop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (instr_o == NOP[XLEN-1:0]));

  assert_stall_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !flush_i) |=> $stable(instr_o));

  assert_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && !flush_i) |=> (instr_o == $past(instr_i)));
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import bru_pkg::*;
#(
  parameter int          XLEN  = 32,
  parameter int          IMM_W = 16,
  parameter int          JT_W  = 26,
  parameter logic [31:0] NOP   = 32'h0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       br_kind_i,
  input  logic [XLEN-1:0]  rs_val_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [JT_W-1:0]  jtgt_i,
  input  logic [XLEN-1:0]  seq_pc_i,
  input  logic             delay_mode_i,
  input  logic             dep_alu_i,
  input  logic [XLEN-1:0]  fetch_instr_i,
  output logic             redirect_o,
  output logic [XLEN-1:0]  target_o,
  output logic             flush_o,
  output logic             stall_o,
  output logic [XLEN-1:0]  dec_instr_o
);
  br_kind_e kind;
  logic     taken;
  logic     is_cond;
  logic     waited_q;
  logic     resolve;

  assign kind    = br_kind_e'(br_kind_i);
  assign is_cond = valid_i && ((kind == BK_BEQZ) || (kind == BK_BNEZ));

  bru_cond #(.XLEN(XLEN)) u_cond (
    .kind_i    (kind),
    .operand_i (rs_val_i),
    .taken_o   (taken)
  );

  bru_target #(.XLEN(XLEN), .IMM_W(IMM_W), .JT_W(JT_W)) u_target (
    .seq_pc_i  (seq_pc_i),
    .imm_i     (imm_i),
    .jtgt_i    (jtgt_i),
    .is_jump_i (kind == BK_JUMP),
    .target_o  (target_o)
  );

  // one-cycle wait for an ALU result feeding the zero test
  assign stall_o    = is_cond && dep_alu_i && !waited_q;
  assign resolve    = valid_i && !stall_o;
  assign redirect_o = resolve && taken;
  assign flush_o    = redirect_o && !delay_mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) waited_q <= 1'b0;
    else         waited_q <= stall_o;
  end

  bru_ifid #(.XLEN(XLEN), .NOP(NOP)) u_ifid (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_o),
    .stall_i (stall_o),
    .instr_i (fetch_instr_i),
    .instr_o (dec_instr_o)
  );

  assert_flush_only_on_redirect_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (redirect_o && !delay_mode_i));

  assert_no_flush_delayed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    delay_mode_i |-> !flush_o);

  assert_single_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !stall_o);

  assert_stall_no_redirect_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !redirect_o);

  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!redirect_o && !flush_o && !stall_o));

  assert_jump_no_stall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind == BK_JUMP) |-> (redirect_o && !stall_o));
endmodule

// File: tb/branch_resolve_unit_tb_top.sv
`timescale 1ns/1ps
module branch_resolve_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid;
  logic [1:0]  kind;
  logic [31:0] rs_val;
  logic [15:0] imm;
  logic [25:0] jtgt;
  logic [31:0] seq_pc;
  logic        dmode;
  logic        dep;
  logic [31:0] finstr;
  logic        redirect, flush, stall;
  logic [31:0] target, dinstr;

  int checks = 0;
  int errors = 0;
  logic        waited_m = 1'b0;
  logic [31:0] exp_dec = 32'h0;

  always #2.5 clk = ~clk;

  branch_resolve_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .br_kind_i(kind),
    .rs_val_i(rs_val), .imm_i(imm), .jtgt_i(jtgt), .seq_pc_i(seq_pc),
    .delay_mode_i(dmode), .dep_alu_i(dep), .fetch_instr_i(finstr),
    .redirect_o(redirect), .target_o(target), .flush_o(flush),
    .stall_o(stall), .dec_instr_o(dinstr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f_target(input logic [1:0] k, input logic [31:0] pc,
                                           input logic [15:0] im, input logic [25:0] jt);
    if (k == 2'b11) return {pc[31:28], jt, 2'b00};
    return pc + {{14{im[15]}}, im, 2'b00};
  endfunction

  function automatic logic f_taken(input logic [1:0] k, input logic [31:0] v);
    case (k)
      2'b01:   return v == 0;
      2'b10:   return v != 0;
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(input logic v, input logic [1:0] k, input logic [31:0] rv,
                      input logic [15:0] im, input logic [25:0] jt, input logic [31:0] pc,
                      input logic dm, input logic dp, input logic [31:0] fi);
    logic e_stall, e_red, e_flush, is_c;
    @(negedge clk);
    chk("R7/R8/R9 dec latch", dinstr, exp_dec);
    valid = v; kind = k; rs_val = rv; imm = im; jtgt = jt; seq_pc = pc;
    dmode = dm; dep = dp; finstr = fi;
    #1;
    is_c    = v && (k == 2'b01 || k == 2'b10);
    e_stall = is_c && dp && !waited_m;
    e_red   = v && !e_stall && f_taken(k, rv);
    e_flush = e_red && !dm;
    chk(k == 2'b11 ? "R4 redirect" : (v ? "R2 redirect" : "R10 redirect"), {31'b0, redirect}, {31'b0, e_red});
    chk(dm ? "R6 flush" : "R5 flush", {31'b0, flush}, {31'b0, e_flush});
    chk(v ? "R9 stall" : "R10 stall", {31'b0, stall}, {31'b0, e_stall});
    if (v && k != 2'b00)
      chk(k == 2'b11 ? "R4 target" : "R3 target", target, f_target(k, pc, im, jt));
    if (e_flush)       exp_dec = 32'h0;
    else if (!e_stall) exp_dec = fi;
    waited_m = e_stall;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    valid = 0; kind = 0; rs_val = 0; imm = 0; jtgt = 0; seq_pc = 0;
    dmode = 0; dep = 0; finstr = 32'hdead_beef;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset nop", dinstr, 32'h0);
    chk("R1 idle stall", {31'b0, stall}, 32'h0);
    chk("R1 idle redirect", {31'b0, redirect}, 32'h0);
    rst_n = 1'b1;

    // R2 zero tests, not-taken vs taken
    step(1, 2'b01, 32'h0, 16'h0004, 0, 32'h0000_1000, 0, 0, 32'h1111_1111);
    step(1, 2'b01, 32'h5, 16'h0004, 0, 32'h0000_1000, 0, 0, 32'h2222_2222);
    step(1, 2'b10, 32'h0, 16'h0004, 0, 32'h0000_1000, 0, 0, 32'h3333_3333);
    step(1, 2'b10, 32'h8000_0000, 16'h8000, 0, 32'h0004_0000, 0, 0, 32'h4444_4444);
    // R3 negative and positive extremes
    step(1, 2'b01, 32'h0, 16'h7fff, 0, 32'hffff_fff0, 0, 0, 32'h5555_5555);
    // R4 jump in both modes, R6 delayed mode
    step(1, 2'b11, 32'h1, 16'h0, 26'h3ff_ffff, 32'hA000_0004, 0, 1, 32'h6666_6666);
    step(1, 2'b11, 32'h1, 16'h0, 26'h000_0001, 32'h5000_0004, 1, 1, 32'h7777_7777);
    step(1, 2'b01, 32'h0, 16'hfffe, 0, 32'h0000_0100, 1, 0, 32'h8888_8888);
    // R9 stall, resolve while dep stays high, then back-to-back dependent branch
    step(1, 2'b01, 32'h0, 16'h0010, 0, 32'h0000_2000, 0, 1, 32'h9999_9999);
    step(1, 2'b01, 32'h0, 16'h0010, 0, 32'h0000_2000, 0, 1, 32'h9999_9999);
    step(1, 2'b10, 32'h7, 16'h0010, 0, 32'h0000_3000, 1, 1, 32'haaaa_aaaa);
    step(1, 2'b10, 32'h7, 16'h0010, 0, 32'h0000_3000, 1, 1, 32'haaaa_aaaa);
    // R10 kind none and invalid slot
    step(1, 2'b00, 32'h0, 16'h0010, 0, 32'h0000_3000, 0, 1, 32'hbbbb_bbbb);
    step(0, 2'b01, 32'h0, 16'h0010, 0, 32'h0000_3000, 0, 1, 32'hcccc_cccc);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] rv;
      rv = ($urandom_range(3) == 0) ? 32'h0 : $urandom;
      step($urandom_range(7) != 0, 2'($urandom), rv, 16'($urandom), 26'($urandom),
           $urandom, 1'($urandom), $urandom_range(3) == 0, $urandom);
    end
    @(negedge clk);
    chk("R7/R8 final latch", dinstr, exp_dec);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule